// File: doc/BRIEF.md
# Register LIFO Stack with Full and Empty Flags

A last-in first-out stack of fixed depth, 64 words by default, held entirely in flip-flops. A stack pointer always addresses the most recently written word. A push first advances the pointer and then stores the incoming word at the new position. A pop first copies the addressed word into an output data register and then moves the pointer back. Two flags, FULL and EMPTY, are updated by every accepted operation.

The write side is a valid/ready stream. `push_ready` depends only on the stack state and is low exactly while the stack is full. A producer that holds `push_valid` while `push_ready` is low is not stalled silently: the beat is dropped and `err` pulses, so a producer must wait for `push_ready` before it offers a word. The read side is a plain request: `pop_req` asks for the top word, and one cycle later `pop_valid` pulses with the word on `pop_data`. `pop_data` keeps its value until the next accepted pop. Requesting a push and a pop in the same cycle is illegal. The stack ignores both requests and flags the conflict on `err`.

Top module: `reg_lifo`

## Requirements
- R1: After reset the pointer is 0, `empty`=1, `full`=0, `push_ready`=1, `err`=0, `pop_valid`=0 and `pop_data`=0.
- R2: A push is accepted when `push_valid`=1, `push_ready`=1 and `pop_req`=0. After the next clock edge the word is stored one position above the previous top, and `empty`=0.
- R3: The push that moves the pointer from DEPTH-1 back to 0 sets `full`=1 and drops `push_ready` to 0, so all DEPTH positions hold data. No earlier push sets `full`.
- R4: A pop is accepted when `pop_req`=1, `push_valid`=0 and `empty`=0. One cycle later `pop_valid`=1 for exactly one cycle and `pop_data` holds the top word. Words come back in the reverse order of their pushes.
- R5: Every accepted pop clears `full`. The pop that moves the pointer to 0 sets `empty`=1, and no other pop does.
- R6: A push offered while `full`=1 (with `pop_req`=0) changes no state, and `err`=1 in the following cycle. A later full drain returns the stored words unchanged.
- R7: A pop requested while `empty`=1 (with `push_valid`=0) changes no state, and `err`=1 in the following cycle. `pop_valid` stays 0 and `pop_data` is unchanged.
- R8: `push_valid`=1 together with `pop_req`=1 in one cycle is an error. Neither operation happens, and `err`=1 in the following cycle.
- R9: `err` is a one-cycle pulse. It is 0 in any cycle that follows a cycle with no illegal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Write beat offered |
| push_ready | output | 1 | Stack can take a word (not full) |
| push_data | input | DATA_W | Word to push |
| pop_req | input | 1 | Request to remove the top word |
| pop_valid | output | 1 | One-cycle pulse: `pop_data` holds a freshly popped word |
| pop_data | output | DATA_W | Output data register |
| full | output | 1 | All DEPTH positions occupied |
| empty | output | 1 | No word stored |
| err | output | 1 | One-cycle pulse after a rejected or conflicting request |

## Verification
The assertions assume that `push_valid` and `pop_req` are always 0 or 1 and never unknown after reset, because the error pulse and the conservation of the pointer are stated for every combination of those two inputs. The bench drives both inputs to known values at every falling edge, so each combination, including the illegal ones, is applied deliberately. It fills the stack to every depth from 1 to DEPTH and drains it each time. It applies illegal pushes at full, illegal pops at empty and conflicting requests at both ends and in the middle. Expected words come from an arithmetic pattern of the push index.

// File: rtl/reg_lifo_pkg.sv
package reg_lifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } lifo_op_e;
endpackage

// File: rtl/reg_lifo_ctrl.sv
module reg_lifo_ctrl
  import reg_lifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic             pop_req,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic             rd_en,
  output logic [PTR_W-1:0] rd_addr,
  output logic             full,
  output logic             empty,
  output logic             err,
  output logic             pop_valid
);
  lifo_op_e         op;
  logic [PTR_W-1:0] sp, sp_up, sp_dn;
  logic             push_acc, pop_acc, bad;

  always_comb begin
    op       = lifo_op_e'({push_valid, pop_req});
    sp_up    = (sp == PTR_W'(DEPTH-1)) ? '0 : sp + PTR_W'(1);
    sp_dn    = (sp == '0) ? PTR_W'(DEPTH-1) : sp - PTR_W'(1);
    push_acc = (op == OP_PUSH) && !full;
    pop_acc  = (op == OP_POP) && !empty;
    bad      = (op == OP_BOTH) || ((op == OP_PUSH) && full) ||
               ((op == OP_POP) && empty);
  end

  assign wr_en   = push_acc;
  assign wr_addr = sp_up;
  assign rd_en   = pop_acc;
  assign rd_addr = sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp        <= '0;
      full      <= 1'b0;
      empty     <= 1'b1;
      err       <= 1'b0;
      pop_valid <= 1'b0;
    end else begin
      err       <= bad;
      pop_valid <= pop_acc;
      if (push_acc) begin
        sp    <= sp_up;
        empty <= 1'b0;
        full  <= (sp_up == '0);
      end else if (pop_acc) begin
        sp    <= sp_dn;
        full  <= 1'b0;
        empty <= (sp_dn == '0);
      end
    end
  end

  // R3: full rises only on the push that wraps the pointer to zero
  a_r3_full_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> (sp == '0) && $past(push_acc));
  // R5: empty implies the pointer sits at zero
  a_r5_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (sp == '0));
  // R5: the two flags never hold together
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R6: a push offered at full leaves the pointer and flags alone
  a_r6_reject_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !pop_req) |=> err && full && $stable(sp));
  // R7: a pop at empty produces no data pulse
  a_r7_reject_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_valid) |=> err && !pop_valid && empty);
  // R8: conflicting requests change no state
  a_r8_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_req) |=> err && $stable(sp) && !pop_valid);
  // R9: without an illegal request err falls
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_valid && !pop_req) |=> !err);
endmodule

// File: rtl/reg_lifo_store.sv
module reg_lifo_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == PTR_W'(i))) mem[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  // R2/R4: storage never reads and writes in the same cycle
  a_r8_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
endmodule

// File: rtl/reg_lifo.sv
module reg_lifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  output logic              err
);
  localparam int PTR_W = $clog2(DEPTH);

  logic             wr_en, rd_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  reg_lifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .pop_req(pop_req),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .full(full), .empty(empty), .err(err), .pop_valid(pop_valid)
  );

  reg_lifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(push_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(pop_data)
  );

  assign push_ready = !full;

  // R4: a data pulse is never reported while the stack claims to be full
  a_r4_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> !full);
endmodule

// File: tb/test_reg_lifo.sv
`timescale 1ns/1ps
module test_reg_lifo;
  localparam int DEPTH  = 64;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              push_valid = 1'b0;
  logic              pop_req = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic              push_ready, pop_valid, full, empty, err;
  logic [DATA_W-1:0] pop_data;

  int checks = 0;
  int errors = 0;
  int count  = 0;
  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] last_pop = '0;
  int seq = 0;

  always #4 clk = ~clk;

  reg_lifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_reg_lifo (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
    .full(full), .empty(empty), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_flags(input string req, input logic exp_err, input logic exp_pv);
    chk({req, " full"},  32'(full),  32'(count == DEPTH));
    chk({req, " empty"}, 32'(empty), 32'(count == 0));
    chk({req, " ready"}, 32'(push_ready), 32'(count != DEPTH));
    chk({req, " err"},   32'(err),   32'(exp_err));
    chk({req, " pop_valid"}, 32'(pop_valid), 32'(exp_pv));
  endtask

  function automatic logic [DATA_W-1:0] pat(input int n);
    return DATA_W'(n * 40503 + 7) ^ DATA_W'(n >> 3);
  endfunction

  // one cycle with the given inputs, sampled at the next falling edge
  task automatic step(input logic pv, input logic pr);
    logic [DATA_W-1:0] d;
    logic illegal, do_push, do_pop;
    d = pat(seq);
    push_valid = pv; pop_req = pr; push_data = d;
    illegal = (pv && pr) || (pv && !pr && count == DEPTH) || (pr && !pv && count == 0);
    do_push = pv && !pr && count < DEPTH;
    do_pop  = pr && !pv && count > 0;
    @(negedge clk);
    push_valid = 1'b0; pop_req = 1'b0;
    if (do_push) begin
      model[count] = d; count++; seq++;
      chk_flags("R2/R3 push", 1'b0, 1'b0);
    end else if (do_pop) begin
      count--;
      last_pop = model[count];
      chk("R4 pop_data", 32'(pop_data), 32'(last_pop));
      chk_flags("R4/R5 pop", 1'b0, 1'b1);
    end else if (illegal) begin
      chk("R6/R7/R8 data hold", 32'(pop_data), 32'(last_pop));
      chk_flags("R6/R7/R8 illegal", 1'b1, 1'b0);
    end else begin
      chk_flags("R9 idle", 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 ready", 32'(push_ready), 32'd1);
    chk("R1 err", 32'(err), 32'd0);
    chk("R1 pop_valid", 32'(pop_valid), 32'd0);
    chk("R1 pop_data", 32'(pop_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: pop at empty, R8: conflict at empty, R9: idle after
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    // sweep every fill depth, drain fully each time
    for (int k = 1; k <= DEPTH; k++) begin
      for (int j = 0; j < k; j++) step(1'b1, 1'b0);
      if (k == DEPTH) begin
        step(1'b1, 1'b0);   // R6 push at full
        step(1'b1, 1'b0);   // R6 again, err stays a pulse per request
        step(1'b0, 1'b0);   // R9
        step(1'b1, 1'b1);   // R8 at full
      end else if (k == DEPTH/2) begin
        step(1'b1, 1'b1);   // R8 mid-depth
      end
      for (int j = 0; j < k; j++) step(1'b0, 1'b1);
      step(1'b0, 1'b1);     // R7 pop at empty
    end
    // R3/R5 wrap: refill, pop one, push one, drain
    for (int j = 0; j < DEPTH; j++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    for (int j = 0; j < DEPTH; j++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule